// File: doc/BRIEF.md
# Floating-Point Compare and Status Unit

This block evaluates one relational predicate between two IEEE-754 operands and records the outcome in a one-bit floating-point status flag. Each operation selects single or double precision on its own, and one predicate decoder serves both widths. For single precision only the low 32 bits of each 64-bit operand bus are examined. For double precision the bus carries an even/odd register pair that the register file has already joined.

The caller pulses `op_valid` for one cycle with the precision select, a 3-bit predicate code and both operands. On the next rising edge the status flag takes the predicate's truth value, and `done` is high for that one cycle. The result is written only to the status flag and never to a general register. Between operations the flag keeps its last value, so later branch logic can read it.

Top module: `fpcmp_status`

## Requirements
- R1: While `rst_n` is low at a clock edge, `fpsr_flag` and `done` become 0 after that edge.
- R2: Predicate codes are 000 less-than, 001 greater-than, 010 equal, 011 less-or-equal, 100 greater-or-equal and 101 not-equal. Operands are ordered first by the sign bit (bit 31 single, bit 63 double). Then they are ordered by the remaining bits read as an unsigned magnitude, and that order is reversed when both operands are negative.
- R3: Equal (010) is true for bit-identical non-NaN operands, and positive zero equals negative zero.
- R4: Less-or-equal (011) and greater-or-equal (100) are true when the strict predicate or equality holds.
- R5: Not-equal (101) is the exact complement of equal (010) for the same operands.
- R6: An operand is a NaN when its exponent field is all ones and its fraction is nonzero. The single-precision exponent is bits 30:23. The double-precision exponent is bits 62:52. If either operand is a NaN, every predicate is false except not-equal, which is true.
- R7: With `op_double` = 0, bits 63:32 of both operands have no effect. With `op_double` = 1, all 64 bits take part: bits 63:32 are the even register (high word) and bits 31:0 are the odd register (low word).
- R8: The unused predicate codes 110 and 111 write 0 into the flag.
- R9: The flag and `done` change on the first clock edge after the edge that samples `op_valid`. `done` is high for exactly one cycle per accepted operation.
- R10: In any cycle where `op_valid` is low, `fpsr_flag` keeps its value and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | One-cycle strobe that starts a comparison |
| op_double | input | 1 | 1 = double precision, 0 = single precision |
| op_pred | input | 3 | Predicate code |
| op_a | input | 64 | Left operand |
| op_b | input | 64 | Right operand |
| fpsr_flag | output | 1 | Floating-point status flag |
| done | output | 1 | One-cycle completion pulse |

## Verification
The checker assumes that the operand, precision and predicate inputs are stable and known whenever `op_valid` is high. It also assumes that `rst_n` is a plain synchronous level that needs no recovery cycles. The bench drives every input on the falling edge and returns `op_valid` to 0 on the falling edge after each operation, so all sampled values are settled and every strobe lasts a single cycle. The equality property covers only operands whose double-precision exponent is not all ones, so it never makes a claim about NaN inputs.

// File: rtl/fpcmp_pkg.sv
// Package: shared widths and predicate encoding for the compare unit.
// Assumes IEEE-754 binary32/binary64 field layouts.
package fpcmp_pkg;
    localparam int OPW    = 64;
    localparam int SPW    = 32;
    localparam int SP_EXP = 8;
    localparam int DP_EXP = 11;

    typedef enum logic [2:0] {
        PRED_LT = 3'd0,
        PRED_GT = 3'd1,
        PRED_EQ = 3'd2,
        PRED_LE = 3'd3,
        PRED_GE = 3'd4,
        PRED_NE = 3'd5
    } pred_e;
endpackage

// File: rtl/fpcmp_unpack.sv
// Module: fpcmp_unpack
// Splits one operand into sign, unsigned magnitude, NaN and zero flags for
// the selected precision. Assumes the single-precision value sits in the low
// SPW bits; the upper bits are ignored in that mode.
module fpcmp_unpack #(
    parameter int OPW    = 64,
    parameter int SPW    = 32,
    parameter int SP_EXP = 8,
    parameter int DP_EXP = 11
) (
    input  logic [OPW-1:0] raw,
    input  logic           is_dbl,
    output logic           sign,
    output logic [OPW-2:0] mag,
    output logic           is_nan,
    output logic           is_zero
);
    localparam int SP_FRAC = SPW - 1 - SP_EXP;
    localparam int DP_FRAC = OPW - 1 - DP_EXP;

    logic exp_ones;
    logic frac_nz;

    // Field extraction according to precision.
    always_comb begin
        mag = '0;
        if (is_dbl) begin
            sign     = raw[OPW-1];
            mag      = raw[OPW-2:0];
            exp_ones = &raw[OPW-2 -: DP_EXP];
            frac_nz  = |raw[DP_FRAC-1:0];
        end else begin
            sign            = raw[SPW-1];
            mag[SPW-2:0]    = raw[SPW-2:0];
            exp_ones        = &raw[SPW-2 -: SP_EXP];
            frac_nz         = |raw[SP_FRAC-1:0];
        end
    end

    // Classification flags.
    always_comb begin
        is_nan  = exp_ones & frac_nz;
        is_zero = (mag == '0);
    end
endmodule

// File: rtl/fpcmp_order.sv
// Module: fpcmp_order
// Derives less-than, equal and unordered relations from two unpacked
// operands of the same precision. Assumes magnitudes are zero-extended alike.
module fpcmp_order #(
    parameter int MAGW = 63
) (
    input  logic            sign_a,
    input  logic            sign_b,
    input  logic [MAGW-1:0] mag_a,
    input  logic [MAGW-1:0] mag_b,
    input  logic            nan_a,
    input  logic            nan_b,
    input  logic            zero_a,
    input  logic            zero_b,
    output logic            rel_lt,
    output logic            rel_eq,
    output logic            rel_un
);
    logic mag_lt;
    logic mag_gt;

    // Raw magnitude relations.
    always_comb begin
        mag_lt = (mag_a < mag_b);
        mag_gt = (mag_a > mag_b);
    end

    // Signed ordering with zero folding and NaN handling.
    always_comb begin
        rel_un = nan_a | nan_b;
        rel_eq = !rel_un && ((zero_a && zero_b) ||
                             (sign_a == sign_b && mag_a == mag_b));
        if (rel_un || rel_eq)
            rel_lt = 1'b0;
        else if (sign_a != sign_b)
            rel_lt = sign_a;
        else if (sign_a)
            rel_lt = mag_gt;
        else
            rel_lt = mag_lt;
    end
endmodule

// File: rtl/fpcmp_pred.sv
// Module: fpcmp_pred
// Maps a predicate code onto the order relations. Assumes rel_lt and rel_eq
// are never both set and are both clear when rel_un is set.
module fpcmp_pred
    import fpcmp_pkg::*;
(
    input  logic [2:0] pred,
    input  logic       rel_lt,
    input  logic       rel_eq,
    input  logic       rel_un,
    output logic       hit
);
    logic rel_gt;

    // Greater-than is what remains of an ordered pair.
    always_comb rel_gt = !rel_un && !rel_lt && !rel_eq;

    // Predicate decode; unused codes yield 0.
    always_comb begin
        case (pred_e'(pred))
            PRED_LT: hit = rel_lt;
            PRED_GT: hit = rel_gt;
            PRED_EQ: hit = rel_eq;
            PRED_LE: hit = rel_lt | rel_eq;
            PRED_GE: hit = rel_gt | rel_eq;
            PRED_NE: hit = !rel_eq;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/fpcmp_status.sv
// Module: fpcmp_status
// Top of the compare unit: unpacks both operands, orders them, decodes the
// predicate and registers the outcome into the status flag with a done pulse.
// Assumes inputs are stable while op_valid is high.
module fpcmp_status
    import fpcmp_pkg::*;
#(
    parameter int W_OP   = OPW,
    parameter int W_SP   = SPW,
    parameter int E_SP   = SP_EXP,
    parameter int E_DP   = DP_EXP
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic            op_double,
    input  logic [2:0]      op_pred,
    input  logic [W_OP-1:0] op_a,
    input  logic [W_OP-1:0] op_b,
    output logic            fpsr_flag,
    output logic            done
);
    localparam int MAGW = W_OP - 1;

    logic [W_OP-1:0] opnd [2];
    logic [1:0]      sgn, nan, zro;
    logic [MAGW-1:0] mag  [2];
    logic            rel_lt, rel_eq, rel_un, hit;

    // Operand array for the unpack generate loop.
    always_comb begin
        opnd[0] = op_a;
        opnd[1] = op_b;
    end

    for (genvar i = 0; i < 2; i++) begin : g_unpack
        fpcmp_unpack #(
            .OPW(W_OP), .SPW(W_SP), .SP_EXP(E_SP), .DP_EXP(E_DP)
        ) u_unpack (
            .raw(opnd[i]), .is_dbl(op_double), .sign(sgn[i]),
            .mag(mag[i]), .is_nan(nan[i]), .is_zero(zro[i])
        );
    end

    fpcmp_order #(.MAGW(MAGW)) u_order (
        .sign_a(sgn[0]), .sign_b(sgn[1]), .mag_a(mag[0]), .mag_b(mag[1]),
        .nan_a(nan[0]), .nan_b(nan[1]), .zero_a(zro[0]), .zero_b(zro[1]),
        .rel_lt(rel_lt), .rel_eq(rel_eq), .rel_un(rel_un)
    );

    fpcmp_pred u_pred (
        .pred(op_pred), .rel_lt(rel_lt), .rel_eq(rel_eq), .rel_un(rel_un),
        .hit(hit)
    );

    // Status flag and done pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fpsr_flag <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= op_valid;
            if (op_valid)
                fpsr_flag <= hit;
        end
    end
endmodule

// File: rtl/fpcmp_status_chk.sv
// Module: fpcmp_status_chk
// Protocol and result properties for fpcmp_status, bound to every instance.
// Assumes inputs are settled whenever op_valid is high.
module fpcmp_status_chk #(
    parameter int W_OP = 64,
    parameter int E_DP = 11
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic            op_double,
    input logic [2:0]      op_pred,
    input logic [W_OP-1:0] op_a,
    input logic [W_OP-1:0] op_b,
    input logic            fpsr_flag,
    input logic            done
);
    localparam int EXP_HI = W_OP - 2;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!done && !fpsr_flag));

    assert_done_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> done);

    assert_idle_no_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !done);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(fpsr_flag));

    assert_identical_equal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_double && op_pred == 3'd2 && op_a == op_b &&
         !(&op_a[EXP_HI -: E_DP])) |=> fpsr_flag);

    assert_unused_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_pred[2:1] == 2'b11) |=> !fpsr_flag);
endmodule

bind fpcmp_status fpcmp_status_chk #(.W_OP(W_OP), .E_DP(E_DP)) u_chk (.*);

// File: tb/fpcmp_status_tb.sv
`timescale 1ns/1ps
module fpcmp_status_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_double = 1'b0;
    logic [2:0]  op_pred = 3'd0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        fpsr_flag, done;
    int          checks = 0;
    int          fails = 0;

    localparam logic [2:0] LT = 3'd0, GT = 3'd1, EQ = 3'd2,
                           LE = 3'd3, GE = 3'd4, NE = 3'd5;

    localparam logic [63:0] S_P1 = 64'h3F800000, S_P2 = 64'h40000000,
                            S_N1 = 64'hBF800000, S_N2 = 64'hC0000000,
                            S_PZ = 64'h0,        S_NZ = 64'h80000000,
                            S_NAN = 64'h7FC00000, S_INF = 64'h7F800000;
    localparam logic [63:0] D_P1 = 64'h3FF0000000000000, D_P2 = 64'h4000000000000000,
                            D_N1 = 64'hBFF0000000000000, D_N2 = 64'hC000000000000000,
                            D_NZ = 64'h8000000000000000, D_NAN = 64'h7FF8000000000000;

    always #2.5 clk = ~clk;

    fpcmp_status u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_double(op_double),
        .op_pred(op_pred), .op_a(op_a), .op_b(op_b),
        .fpsr_flag(fpsr_flag), .done(done)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // One operation: strobe, then check flag and done one edge later.
    task automatic cmp(input string tag, input logic dbl, input logic [2:0] p,
                       input logic [63:0] a, input logic [63:0] b, input logic exp);
        @(negedge clk);
        op_valid = 1'b1; op_double = dbl; op_pred = p; op_a = a; op_b = b;
        @(posedge clk); #1;
        check({tag, " flag"}, fpsr_flag, exp);
        check("R9 done", done, 1'b1);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R1 flag", fpsr_flag, 1'b0);
        check("R1 done", done, 1'b0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic test_single_order();
        cmp("R2 sp 1<2", 1'b0, LT, S_P1, S_P2, 1'b1);
        cmp("R2 sp 2<1", 1'b0, LT, S_P2, S_P1, 1'b0);
        cmp("R2 sp -2<-1", 1'b0, LT, S_N2, S_N1, 1'b1);
        cmp("R2 sp -1>-2", 1'b0, GT, S_N1, S_N2, 1'b1);
        cmp("R2 sp -1<1", 1'b0, LT, S_N1, S_P1, 1'b1);
        cmp("R2 sp inf>2", 1'b0, GT, S_INF, S_P2, 1'b1);
        cmp("R4 sp 1<=1", 1'b0, LE, S_P1, S_P1, 1'b1);
        cmp("R4 sp 2<=1", 1'b0, LE, S_P2, S_P1, 1'b0);
        cmp("R4 sp -1>=-2", 1'b0, GE, S_N1, S_N2, 1'b1);
    endtask

    task automatic test_double_order();
        cmp("R2 dp 1<2", 1'b1, LT, D_P1, D_P2, 1'b1);
        cmp("R2 dp -2>-1", 1'b1, GT, D_N2, D_N1, 1'b0);
        cmp("R2 dp 2>-2", 1'b1, GT, D_P2, D_N2, 1'b1);
        cmp("R3 dp 1==1", 1'b1, EQ, D_P1, D_P1, 1'b1);
        cmp("R4 dp 1>=2", 1'b1, GE, D_P1, D_P2, 1'b0);
        cmp("R4 dp -2<=-2", 1'b1, LE, D_N2, D_N2, 1'b1);
        cmp("R5 dp 1!=2", 1'b1, NE, D_P1, D_P2, 1'b1);
        cmp("R5 dp 1!=1", 1'b1, NE, D_P1, D_P1, 1'b0);
    endtask

    task automatic test_zero();
        cmp("R3 sp +0==-0", 1'b0, EQ, S_PZ, S_NZ, 1'b1);
        cmp("R3 sp -0<+0", 1'b0, LT, S_NZ, S_PZ, 1'b0);
        cmp("R3 dp -0==+0", 1'b1, EQ, D_NZ, 64'h0, 1'b1);
        cmp("R5 dp -0!=+0", 1'b1, NE, D_NZ, 64'h0, 1'b0);
    endtask

    task automatic test_nan();
        cmp("R6 sp nan<1", 1'b0, LT, S_NAN, S_P1, 1'b0);
        cmp("R6 sp 1>nan", 1'b0, GT, S_P1, S_NAN, 1'b0);
        cmp("R6 sp nan==nan", 1'b0, EQ, S_NAN, S_NAN, 1'b0);
        cmp("R6 sp nan<=1", 1'b0, LE, S_NAN, S_P1, 1'b0);
        cmp("R6 dp nan>=1", 1'b1, GE, D_P1, D_NAN, 1'b0);
        cmp("R6 dp nan!=nan", 1'b1, NE, D_NAN, D_NAN, 1'b1);
        cmp("R6 sp inf==inf", 1'b0, EQ, S_INF, S_INF, 1'b1);
    endtask

    task automatic test_precision();
        cmp("R7 sp high ignored", 1'b0, EQ, {32'hFFFFFFFF, 32'h3F800000},
            {32'h0, 32'h3F800000}, 1'b1);
        cmp("R7 sp high ignored lt", 1'b0, LT, {32'h0, 32'h40000000},
            {32'h7FFFFFFF, 32'h3F800000}, 1'b0);
        cmp("R7 dp high used", 1'b1, EQ, {32'hFFFFFFFF, 32'h3F800000},
            {32'h0, 32'h3F800000}, 1'b0);
        cmp("R7 dp low word", 1'b1, GT, 64'h3FF0000000000001, D_P1, 1'b1);
    endtask

    task automatic test_reserved();
        cmp("R8 code 110", 1'b0, 3'd6, S_P1, S_P1, 1'b0);
        cmp("R2 set before 111", 1'b0, LT, S_P1, S_P2, 1'b1);
        cmp("R8 code 111", 1'b1, 3'd7, D_P1, D_P2, 1'b0);
    endtask

    task automatic test_hold();
        cmp("R10 prime", 1'b0, GT, S_P2, S_P1, 1'b1);
        @(negedge clk);
        op_pred = LT; op_a = S_P2; op_b = S_P1;
        repeat (3) @(posedge clk);
        #1;
        check("R10 flag held", fpsr_flag, 1'b1);
        check("R10 done low", done, 1'b0);
    endtask

    task automatic test_done_pulse();
        cmp("R9 op", 1'b0, EQ, S_P1, S_P1, 1'b1);
        @(posedge clk); #1;
        check("R9 done single cycle", done, 1'b0);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        test_reset();
        test_single_order();
        test_double_order();
        test_zero();
        test_nan();
        test_precision();
        test_reserved();
        test_hold();
        test_done_pulse();
        test_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule